// File: doc/BRIEF.md
# Integer ALU and Address Generator

This block is the integer execution unit of a signal-processing core. One operation per cycle enters with an opcode, three register indices, an immediate, an option field and a buffer select. It reads two 32-bit operands from a bank of 31 general registers. It then does one of two things. It can compute an arithmetic, logical, shift, rotate, absolute-value or min/max result and update the zero, negative, overflow and carry flags. Or it can act as a data address generator: it outputs the current index register and writes back a post-modified index. The new index can wrap inside a circular buffer or step in bit-reversed order.

The result, the address and the flags are registered, so they appear one cycle after the operation is accepted. Four circular buffers each hold a base and a length. These are loaded by dedicated opcodes. A combinational condition output evaluates a selected comparison against the current flags. Software uses it to decide predicated work without reading the flags.

Top module: `ialu_top`

## Requirements
- R1: When `in_valid` is high at a rising edge, `res_valid`, `result`, `addr_out` and the flags take new values at that edge. `res_valid` is low after any edge at which `in_valid` was low.
- R2: Flags are encoded as `flags_o` = {Z,N,V,C} (bit 3 Z, bit 0 C). ADD (op 0) writes a+b and sets C to the carry out and V to signed overflow. SUB (op 1) writes a-b and sets C when a<b unsigned (borrow) and V to signed overflow. Z and N follow the result.
- R3: CMP (op 13) updates the flags as SUB does but writes no register. LDI (op 14, rd=imm), ADDR (op 15), SETB (op 16) and SETL (op 17) leave the flags unchanged.
- R4: ASHR (op 2) and LSHR (op 3) shift a right, arithmetic or logical, by b[4:0]. ROTL (op 4) and ROTR (op 5) rotate a by b[4:0] left or right. There is no left shift.
- R5: ANDN (op 6, a & ~b), NOT (op 7, ~a), OR (op 8) and XOR (op 9) clear V and C. Shifts and rotates also clear V and C.
- R6: ABS (op 10) yields |a|. For 0x80000000 it yields the same value with V=1. MIN (op 11) and MAX (op 12) compare signed, or unsigned when option bit 0 (U) is set.
- R7: `cond_true` evaluates `cond_sel` against the current flags: 0 EQ, 1 LT, 2 LE, 3 NEQ, 4 NLT, 5 NLE, codes 6 and 7 false. LT is N^V when `opts[0]` is clear and C when it is set. LE is LT|Z. NLT and NLE are the negations of LT and LE.
- R8: ADDR outputs register ra on `addr_out` and writes next = ra+rb back into ra, which also appears on `result`. With option bit 1 (CB) set and buffer `cb_sel` holding base B and length L: if next ≥ B+L then L is subtracted, and if next < B then L is added.
- R9: With option bit 2 (BR) set and CB clear, ADDR adds rb to ra with the carry running from bit 31 toward bit 0. CB takes priority over BR.
- R10: Register indices 0 to 30 are general registers. Reading index 31 returns {28'b0,Z,N,V,C}. A write to index 31 is discarded.
- R11: SETB and SETL load `imm` into the base or length of buffer `cb_sel`. Synchronous reset clears all registers, buffers, flags and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 5 | Opcode |
| ra | input | 5 | First source / index register |
| rb | input | 5 | Second source / modifier register |
| rd | input | 5 | Destination register |
| opts | input | 3 | Options: bit 0 U, bit 1 CB, bit 2 BR |
| cb_sel | input | 2 | Circular buffer select |
| imm | input | 32 | Immediate for LDI, SETB, SETL |
| cond_sel | input | 3 | Condition code to evaluate |
| res_valid | output | 1 | Registered result valid |
| result | output | 32 | Registered result |
| addr_out | output | 32 | Registered pre-modify address |
| flags_o | output | 4 | Flags {Z,N,V,C} |
| cond_true | output | 1 | Selected condition holds |

## Verification
The bench targets the flag boundaries. These are signed overflow at 0x7fffffff+1 and 0x80000000-1, carry out at 0xffffffff+1, and the borrow polarity of SUB. A wrong borrow sense would invert every unsigned LT. It compares -1 with 1 both signed and unsigned, where a design that ignored U would give the same answer twice. It also covers ABS of the most negative value. Circular wraps are driven past both the top and the bottom of a buffer, where a missing lower check would leave the index below base. A three-step bit-reversed sequence exposes a carry running the wrong way. Status reads and discarded writes at index 31, and flags held across CMP-free load and address operations, catch a design that aliases the status register or lets non-ALU operations disturb the flags.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
    localparam int DW    = 32;
    localparam int RIW   = 5;
    localparam int NGP   = 31;
    localparam int NCB   = 4;
    localparam int CBW   = $clog2(NCB);

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_ASHR = 5'd2,  OP_LSHR = 5'd3,
        OP_ROTL = 5'd4,  OP_ROTR = 5'd5,  OP_ANDN = 5'd6,  OP_NOT  = 5'd7,
        OP_OR   = 5'd8,  OP_XOR  = 5'd9,  OP_ABS  = 5'd10, OP_MIN  = 5'd11,
        OP_MAX  = 5'd12, OP_CMP  = 5'd13, OP_LDI  = 5'd14, OP_ADDR = 5'd15,
        OP_SETB = 5'd16, OP_SETL = 5'd17
    } op_e;

    typedef enum logic [2:0] {
        CC_EQ = 3'd0, CC_LT = 3'd1, CC_LE = 3'd2,
        CC_NE = 3'd3, CC_NLT = 3'd4, CC_NLE = 3'd5
    } cond_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        logic br;
        logic cb;
        logic u;
    } opt_t;

    function automatic logic [DW-1:0] bitrev(input logic [DW-1:0] x);
        logic [DW-1:0] y;
        for (int i = 0; i < DW; i++) y[i] = x[DW-1-i];
        return y;
    endfunction

    function automatic logic cond_eval(input flags_t f, input logic [2:0] cs, input logic u);
        logic lt;
        logic le;
        lt = u ? f.c : (f.n ^ f.v);
        le = lt | f.z;
        case (cs)
            CC_EQ:   return f.z;
            CC_LT:   return lt;
            CC_LE:   return le;
            CC_NE:   return !f.z;
            CC_NLT:  return !lt;
            CC_NLE:  return !le;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/ialu_regfile.sv
module ialu_regfile #(
    parameter int W  = ialu_pkg::DW,
    parameter int N  = ialu_pkg::NGP,
    parameter int AW = ialu_pkg::RIW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] bank [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                bank[gi] <= '0;
            else if (we && waddr == AW'(gi))        bank[gi] <= wdata;
        end
    end

    assign rdata_a = (raddr_a < AW'(N)) ? bank[raddr_a] : '0;
    assign rdata_b = (raddr_b < AW'(N)) ? bank[raddr_b] : '0;
endmodule

// File: rtl/ialu_exec.sv
module ialu_exec
    import ialu_pkg::*;
#(
    parameter int W = DW
) (
    input  op_e          op,
    input  logic         uns,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] imm,
    output logic [W-1:0] res,
    output flags_t       fl,
    output logic         wr_en,
    output logic         fl_en
);
    localparam int SW = $clog2(W);

    logic [W:0]    sum_w;
    logic [W:0]    dif_w;
    logic [SW-1:0] sh;
    logic [SW:0]   inv;
    logic          a_lt_b;
    logic          ov;
    logic          cy;

    assign sum_w  = {1'b0, a} + {1'b0, b};
    assign dif_w  = {1'b0, a} - {1'b0, b};
    assign sh     = b[SW-1:0];
    assign inv    = (SW+1)'(W) - {1'b0, sh};
    assign a_lt_b = uns ? (a < b) : ($signed(a) < $signed(b));

    always_comb begin
        res   = '0;
        ov    = 1'b0;
        cy    = 1'b0;
        wr_en = 1'b1;
        fl_en = 1'b1;
        case (op)
            OP_ADD: begin
                res = sum_w[W-1:0];
                cy  = sum_w[W];
                ov  = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
            end
            OP_SUB, OP_CMP: begin
                res   = dif_w[W-1:0];
                cy    = dif_w[W];
                ov    = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
                wr_en = (op == OP_SUB);
            end
            OP_ASHR: res = W'($signed(a) >>> sh);
            OP_LSHR: res = a >> sh;
            OP_ROTL: res = (a << sh) | (a >> inv);
            OP_ROTR: res = (a >> sh) | (a << inv);
            OP_ANDN: res = a & ~b;
            OP_NOT:  res = ~a;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_ABS: begin
                res = a[W-1] ? (~a + 1'b1) : a;
                ov  = a[W-1] && (a[W-2:0] == '0);
            end
            OP_MIN:  res = a_lt_b ? a : b;
            OP_MAX:  res = a_lt_b ? b : a;
            OP_LDI: begin
                res   = imm;
                fl_en = 1'b0;
            end
            default: begin
                res   = imm;
                wr_en = 1'b0;
                fl_en = 1'b0;
            end
        endcase
        fl.z = (res == '0);
        fl.n = res[W-1];
        fl.v = ov;
        fl.c = cy;
    end
endmodule

// File: rtl/ialu_agu.sv
module ialu_agu
    import ialu_pkg::*;
#(
    parameter int W  = DW,
    parameter int NB = NCB,
    parameter int BW = CBW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_base,
    input  logic          set_len,
    input  logic [BW-1:0] sel,
    input  logic [W-1:0]  wval,
    input  logic [W-1:0]  idx,
    input  logic [W-1:0]  mdf,
    input  opt_t          opt,
    output logic [W-1:0]  next
);
    logic [W-1:0] base_r [NB];
    logic [W-1:0] len_r  [NB];

    for (genvar gb = 0; gb < NB; gb++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst) begin
                base_r[gb] <= '0;
                len_r[gb]  <= '0;
            end else begin
                if (set_base && sel == BW'(gb)) base_r[gb] <= wval;
                if (set_len  && sel == BW'(gb)) len_r[gb]  <= wval;
            end
        end
    end

    logic [W-1:0] lin;
    logic [W-1:0] cb_base;
    logic [W-1:0] cb_len;
    logic [W:0]   cb_top;
    logic [W-1:0] circ;
    logic [W-1:0] rev;

    assign lin     = idx + mdf;
    assign cb_base = base_r[sel];
    assign cb_len  = len_r[sel];
    assign cb_top  = {1'b0, cb_base} + {1'b0, cb_len};
    assign rev     = bitrev(bitrev(idx) + bitrev(mdf));

    always_comb begin
        if ({1'b0, lin} >= cb_top)  circ = lin - cb_len;
        else if (lin < cb_base)     circ = lin + cb_len;
        else                        circ = lin;
    end

    always_comb begin
        if (opt.cb)       next = circ;
        else if (opt.br)  next = rev;
        else              next = lin;
    end
endmodule

// File: rtl/ialu_top.sv
module ialu_top
    import ialu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [4:0]        op,
    input  logic [RIW-1:0]    ra,
    input  logic [RIW-1:0]    rb,
    input  logic [RIW-1:0]    rd,
    input  logic [2:0]        opts,
    input  logic [CBW-1:0]    cb_sel,
    input  logic [DW-1:0]     imm,
    input  logic [2:0]        cond_sel,
    output logic              res_valid,
    output logic [DW-1:0]     result,
    output logic [DW-1:0]     addr_out,
    output logic [3:0]        flags_o,
    output logic              cond_true
);
    localparam logic [RIW-1:0] STAT_IDX = RIW'(NGP);

    op_e          op_i;
    opt_t         opt_i;
    flags_t       flags_q;
    flags_t       ex_fl;
    logic [DW-1:0] rf_a, rf_b, opa, opb, ex_res, agu_next, wb_data;
    logic         ex_we, ex_fe, is_addr, wb_en;
    logic [RIW-1:0] wb_idx;

    assign op_i  = op_e'(op);
    assign opt_i = opt_t'(opts);

    assign opa = (ra == STAT_IDX) ? {{(DW-4){1'b0}}, flags_q} : rf_a;
    assign opb = (rb == STAT_IDX) ? {{(DW-4){1'b0}}, flags_q} : rf_b;

    ialu_exec #(.W(DW)) u_exec (
        .op(op_i), .uns(opt_i.u), .a(opa), .b(opb), .imm(imm),
        .res(ex_res), .fl(ex_fl), .wr_en(ex_we), .fl_en(ex_fe)
    );

    ialu_agu #(.W(DW), .NB(NCB), .BW(CBW)) u_agu (
        .clk(clk), .rst(rst),
        .set_base(in_valid && op_i == OP_SETB),
        .set_len(in_valid && op_i == OP_SETL),
        .sel(cb_sel), .wval(imm), .idx(opa), .mdf(opb), .opt(opt_i),
        .next(agu_next)
    );

    assign is_addr = (op_i == OP_ADDR);
    assign wb_data = is_addr ? agu_next : ex_res;
    assign wb_idx  = is_addr ? ra : rd;
    assign wb_en   = in_valid && (is_addr || ex_we);

    ialu_regfile #(.W(DW), .N(NGP), .AW(RIW)) u_rf (
        .clk(clk), .rst(rst), .we(wb_en), .waddr(wb_idx), .wdata(wb_data),
        .raddr_a(ra), .raddr_b(rb), .rdata_a(rf_a), .rdata_b(rf_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            result    <= '0;
            addr_out  <= '0;
            flags_q   <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                result <= wb_data;
                if (is_addr) addr_out <= opa;
                if (ex_fe)   flags_q  <= ex_fl;
            end
        end
    end

    assign flags_o   = flags_q;
    assign cond_true = cond_eval(flags_q, cond_sel, opt_i.u);
endmodule

// File: rtl/ialu_chk.sv
module ialu_chk
    import ialu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [4:0] op,
    input logic [2:0] cond_sel,
    input logic       res_valid,
    input logic [3:0] flags_o,
    input logic       cond_true
);
    logic quiet_op;
    logic logic_op;
    assign quiet_op = (op == OP_LDI) || (op == OP_ADDR) || (op == OP_SETB) || (op == OP_SETL);
    assign logic_op = (op == OP_ANDN) || (op == OP_NOT) || (op == OP_OR) || (op == OP_XOR)
                   || (op == OP_ASHR) || (op == OP_LSHR) || (op == OP_ROTL) || (op == OP_ROTR);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);
    assert_idle_no_valid_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);
    assert_flags_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || quiet_op) |=> $stable(flags_o));
    assert_logic_clears_vc_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && logic_op) |=> (flags_o[1:0] == 2'b00));
    assert_neq_opposes_eq_R7: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == CC_NE) |-> (cond_true == !flags_o[3]));
    assert_high_codes_false_R7: assert property (@(posedge clk) disable iff (rst)
        (cond_sel > 3'd5) |-> !cond_true);
endmodule

bind ialu_top ialu_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .cond_sel(cond_sel),
    .res_valid(res_valid), .flags_o(flags_o), .cond_true(cond_true)
);

// File: tb/ialu_top_tb.sv
`timescale 1ns/1ps
module ialu_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [4:0]  ra = '0, rb = '0, rd = '0;
    logic [2:0]  opts = '0;
    logic [1:0]  cb_sel = '0;
    logic [31:0] imm = '0;
    logic [2:0]  cond_sel = '0;
    logic        res_valid;
    logic [31:0] result, addr_out;
    logic [3:0]  flags_o;
    logic        cond_true;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ialu_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .ra(ra), .rb(rb),
        .rd(rd), .opts(opts), .cb_sel(cb_sel), .imm(imm), .cond_sel(cond_sel),
        .res_valid(res_valid), .result(result), .addr_out(addr_out),
        .flags_o(flags_o), .cond_true(cond_true)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] o, input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] d, input logic [2:0] opt, input logic [31:0] im);
        @(negedge clk);
        op = o; ra = a; rb = b; rd = d; opts = opt; imm = im; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic ldi(input logic [4:0] d, input logic [31:0] v);
        issue(5'd14, 5'd0, 5'd0, d, 3'b000, v);
    endtask

    task automatic rdreg(input logic [4:0] r);
        issue(5'd8, r, r, 5'd30, 3'b000, 32'h0);
    endtask

    task automatic cond_chk(input string req, input logic [2:0] cs, input logic u, input logic exp);
        cond_sel = cs; opts = {2'b00, u};
        #1;
        check(req, $sformatf("cond %0d u=%0d", cs, u), {31'b0, cond_true}, {31'b0, exp});
    endtask

    task automatic t_reset;
        check("R11", "res_valid after reset", {31'b0, res_valid}, 32'h0);
        check("R11", "flags after reset", {28'b0, flags_o}, 32'h0);
        check("R11", "result after reset", result, 32'h0);
        rdreg(5'd7);
        check("R11", "register cleared", result, 32'h0);
    endtask

    task automatic t_latency;
        ldi(5'd1, 32'h55);
        check("R1", "valid one cycle after", {31'b0, res_valid}, 32'h1);
        check("R1", "ldi result", result, 32'h55);
        @(negedge clk);
        check("R1", "valid drops when idle", {31'b0, res_valid}, 32'h0);
    endtask

    task automatic t_addsub;
        ldi(5'd1, 32'h7fffffff); ldi(5'd2, 32'h1);
        issue(5'd0, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        check("R2", "add overflow value", result, 32'h80000000);
        check("R2", "add overflow flags", {28'b0, flags_o}, 32'h6);
        ldi(5'd1, 32'hffffffff);
        issue(5'd0, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        check("R2", "add carry value", result, 32'h0);
        check("R2", "add carry flags", {28'b0, flags_o}, 32'h9);
        ldi(5'd1, 32'h3); ldi(5'd2, 32'h5);
        issue(5'd1, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        check("R2", "sub borrow value", result, 32'hfffffffe);
        check("R2", "sub borrow flags", {28'b0, flags_o}, 32'h5);
        ldi(5'd1, 32'h80000000); ldi(5'd2, 32'h1);
        issue(5'd1, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        check("R2", "sub overflow value", result, 32'h7fffffff);
        check("R2", "sub overflow flags", {28'b0, flags_o}, 32'h2);
    endtask

    task automatic t_cmp;
        ldi(5'd9, 32'h1234); ldi(5'd1, 32'h5);
        issue(5'd13, 5'd1, 5'd1, 5'd9, 3'b000, 32'h0);
        check("R3", "cmp equal flags", {28'b0, flags_o}, 32'h8);
        ldi(5'd4, 32'habcd);
        check("R3", "ldi keeps flags", {28'b0, flags_o}, 32'h8);
        rdreg(5'd9);
        check("R3", "cmp writes no register", result, 32'h1234);
    endtask

    task automatic t_shift;
        ldi(5'd1, 32'h80000010); ldi(5'd2, 32'h4);
        issue(5'd2, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        check("R4", "ashr", result, 32'hf8000001);
        check("R5", "ashr flags", {28'b0, flags_o}, 32'h4);
        issue(5'd3, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        check("R4", "lshr", result, 32'h08000001);
        ldi(5'd1, 32'h80000001); ldi(5'd2, 32'h1);
        issue(5'd4, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        check("R4", "rotl", result, 32'h00000003);
        issue(5'd5, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        check("R4", "rotr", result, 32'hc0000000);
        ldi(5'd2, 32'h0);
        issue(5'd5, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        check("R4", "rotr by zero", result, 32'h80000001);
    endtask

    task automatic t_logic;
        ldi(5'd5, 32'hff00ff00); ldi(5'd6, 32'h0ff00ff0);
        ldi(5'd1, 32'hffffffff); ldi(5'd2, 32'h1);
        issue(5'd0, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        issue(5'd6, 5'd5, 5'd6, 5'd3, 3'b000, 32'h0);
        check("R5", "andn", result, 32'hf000f000);
        check("R5", "andn clears carry", {28'b0, flags_o}, 32'h4);
        issue(5'd7, 5'd5, 5'd6, 5'd3, 3'b000, 32'h0);
        check("R5", "not", result, 32'h00ff00ff);
        issue(5'd8, 5'd5, 5'd6, 5'd3, 3'b000, 32'h0);
        check("R5", "or", result, 32'hfff0fff0);
        issue(5'd9, 5'd5, 5'd6, 5'd3, 3'b000, 32'h0);
        check("R5", "xor", result, 32'hf0f0f0f0);
    endtask

    task automatic t_absminmax;
        ldi(5'd7, 32'hfffffffb);
        issue(5'd10, 5'd7, 5'd7, 5'd3, 3'b000, 32'h0);
        check("R6", "abs -5", result, 32'h5);
        ldi(5'd8, 32'h80000000);
        issue(5'd10, 5'd8, 5'd8, 5'd3, 3'b000, 32'h0);
        check("R6", "abs min value", result, 32'h80000000);
        check("R6", "abs min flags", {28'b0, flags_o}, 32'h6);
        ldi(5'd1, 32'hffffffff); ldi(5'd2, 32'h1);
        issue(5'd11, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        check("R6", "min signed", result, 32'hffffffff);
        issue(5'd11, 5'd1, 5'd2, 5'd3, 3'b001, 32'h0);
        check("R6", "min unsigned", result, 32'h1);
        issue(5'd12, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        check("R6", "max signed", result, 32'h1);
        issue(5'd12, 5'd1, 5'd2, 5'd3, 3'b001, 32'h0);
        check("R6", "max unsigned", result, 32'hffffffff);
    endtask

    task automatic t_cond;
        ldi(5'd1, 32'h3); ldi(5'd2, 32'h5);
        issue(5'd13, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        cond_chk("R7", 3'd1, 1'b0, 1'b1);
        cond_chk("R7", 3'd1, 1'b1, 1'b1);
        cond_chk("R7", 3'd0, 1'b0, 1'b0);
        cond_chk("R7", 3'd3, 1'b0, 1'b1);
        cond_chk("R7", 3'd4, 1'b0, 1'b0);
        ldi(5'd1, 32'hffffffff); ldi(5'd2, 32'h1);
        issue(5'd13, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        cond_chk("R7", 3'd1, 1'b0, 1'b1);
        cond_chk("R7", 3'd1, 1'b1, 1'b0);
        cond_chk("R7", 3'd4, 1'b1, 1'b1);
        issue(5'd13, 5'd2, 5'd2, 5'd3, 3'b000, 32'h0);
        cond_chk("R7", 3'd0, 1'b0, 1'b1);
        cond_chk("R7", 3'd2, 1'b0, 1'b1);
        cond_chk("R7", 3'd1, 1'b0, 1'b0);
        cond_chk("R7", 3'd5, 1'b0, 1'b0);
        cond_chk("R7", 3'd7, 1'b0, 1'b0);
        cond_sel = 3'd0; opts = 3'd0;
    endtask

    task automatic t_circ;
        logic [3:0] f_before;
        issue(5'd16, 5'd0, 5'd0, 5'd0, 3'b000, 32'd100);
        issue(5'd17, 5'd0, 5'd0, 5'd0, 3'b000, 32'd10);
        cb_sel = 2'd1;
        issue(5'd16, 5'd0, 5'd0, 5'd0, 3'b000, 32'd100);
        issue(5'd17, 5'd0, 5'd0, 5'd0, 3'b000, 32'd10);
        ldi(5'd10, 32'd105); ldi(5'd11, 32'd7);
        f_before = flags_o;
        issue(5'd15, 5'd10, 5'd11, 5'd0, 3'b010, 32'h0);
        check("R8", "addr out pre-modify", addr_out, 32'd105);
        check("R8", "wrap past top", result, 32'd102);
        check("R3", "addr keeps flags", {28'b0, flags_o}, {28'b0, f_before});
        issue(5'd15, 5'd10, 5'd11, 5'd0, 3'b010, 32'h0);
        check("R8", "index written back", addr_out, 32'd102);
        check("R8", "no wrap inside", result, 32'd109);
        ldi(5'd10, 32'd101); ldi(5'd11, 32'hfffffffd);
        issue(5'd15, 5'd10, 5'd11, 5'd0, 3'b010, 32'h0);
        check("R8", "wrap below base", result, 32'd108);
        ldi(5'd10, 32'd105); ldi(5'd11, 32'd7);
        issue(5'd15, 5'd10, 5'd11, 5'd0, 3'b000, 32'h0);
        check("R8", "linear without CB", result, 32'd112);
        ldi(5'd10, 32'd105);
        issue(5'd15, 5'd10, 5'd11, 5'd0, 3'b110, 32'h0);
        check("R9", "CB over BR priority", result, 32'd102);
        cb_sel = 2'd0;
    endtask

    task automatic t_bitrev;
        ldi(5'd12, 32'h0); ldi(5'd13, 32'h80000000);
        issue(5'd15, 5'd12, 5'd13, 5'd0, 3'b100, 32'h0);
        check("R9", "br step 1", result, 32'h80000000);
        issue(5'd15, 5'd12, 5'd13, 5'd0, 3'b100, 32'h0);
        check("R9", "br step 2", result, 32'h40000000);
        issue(5'd15, 5'd12, 5'd13, 5'd0, 3'b100, 32'h0);
        check("R9", "br step 3 addr", addr_out, 32'h40000000);
        check("R9", "br step 3", result, 32'hc0000000);
    endtask

    task automatic t_status;
        ldi(5'd1, 32'hffffffff); ldi(5'd2, 32'h1);
        issue(5'd0, 5'd1, 5'd2, 5'd3, 3'b000, 32'h0);
        rdreg(5'd31);
        check("R10", "status read", result, 32'h9);
        ldi(5'd31, 32'hdeadbeef);
        rdreg(5'd31);
        check("R10", "status write discarded", result, 32'h0);
        ldi(5'd0, 32'hcafe0001); ldi(5'd30, 32'h0);
        rdreg(5'd0);
        check("R10", "register 0 general", result, 32'hcafe0001);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_addsub();
        t_cmp();
        t_shift();
        t_logic();
        t_absminmax();
        t_cond();
        t_circ();
        t_bitrev();
        t_status();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule